// File: doc/BRIEF.md
# Shift Execution Unit

This block performs the shift operations of a 32-bit single-cycle integer datapath that uses a load/store instruction set. Each cycle it takes the instruction word, the two register read values and a valid strobe. It recognises the six shift operations: left logical, right logical and right arithmetic, each in a fixed-count form and a variable-count form.

For a fixed-count shift, the count comes from the 5-bit shift-amount field of the instruction, bits [10:6]. For a variable-count shift, the count comes from the low five bits of the first source register. In every form the value that is shifted comes from the second register read port (rt), never from the first (rs).

The block registers its outputs, in keeping with an FPGA pipeline boundary. It returns the shift result and a flag that tells the writeback stage that a shift was executed. For anything that is not a shift, the result is zero.

Top module: `shift_unit`

## Requirements
- R1: After a synchronous active-high reset, `result_out` is 0 and `is_shift_out` is 0.
- R2: `is_shift_out` is 1 exactly when the sampled `valid_in` was 1, opcode bits [31:26] were 0, and funct bits [5:0] were one of 0x00, 0x02, 0x03, 0x04, 0x06 or 0x07.
- R3: When `is_shift_out` is 0, `result_out` is 0. This includes a nonzero opcode and any other funct value.
- R4: Funct 0x00 gives rt shifted left by instr[10:6], with the vacated low bits filled with zeros.
- R5: Funct 0x02 gives rt shifted right by instr[10:6], with zero fill. For example, 0xF0000000 shifted by 30 gives 0x00000003.
- R6: Funct 0x03 gives rt shifted right by instr[10:6], with bit 31 of rt copied into the vacated high bits.
- R7: Funct 0x04, 0x06 and 0x07 perform the left-logical, right-logical and right-arithmetic shifts with the count taken from rs[4:0]. Bits rs[31:5] have no effect.
- R8: For the fixed-count forms, the rs value has no effect on the result.
- R9: Outputs reflect the inputs sampled on the previous rising clock edge, with a latency of exactly one cycle.
- R10: A count of 0 returns rt unchanged, in every shift form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Instruction word and operands are valid |
| instr_in | input | 32 | Instruction word |
| rs_val | input | 32 | First register read value; supplies the variable count |
| rt_val | input | 32 | Second register read value; the operand that is shifted |
| result_out | output | 32 | Registered shift result, or 0 for a non-shift |
| is_shift_out | output | 1 | Registered flag marking an executed shift |

## Verification
The assertions check the following on every cycle:
- the flag is never set unless a valid opcode-0 word was sampled;
- a cleared flag always comes with a zero result;
- a left shift leaves zeros in the low bits;
- a logical right shift clears the top bit;
- an arithmetic right shift keeps the sign bit;
- a zero count passes the operand through unchanged.

Some behaviours only the bench can show:
- the exact shifted values, such as 0xF0000000 shifted right by 30 giving 3;
- that the upper bits of rs, and the whole of rs in the fixed forms, are ignored;
- the exact decode of every funct value against the reference model.

// File: rtl/shift_pkg.sv
package shift_pkg;
  localparam int INSTR_W = 32;
  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_SLLV = 6'h04;
  localparam logic [5:0] FN_SRLV = 6'h06;
  localparam logic [5:0] FN_SRAV = 6'h07;

  typedef enum logic [1:0] {
    KIND_LL = 2'd0,
    KIND_RL = 2'd1,
    KIND_RA = 2'd2
  } shift_kind_e;

  typedef struct packed {
    logic        hit;
    logic        from_reg;
    shift_kind_e kind;
  } shift_dec_t;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shift_pkg::*;
(
  input  logic       valid,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output shift_dec_t dec
);
  always_comb begin
    dec.hit      = 1'b0;
    dec.from_reg = 1'b0;
    dec.kind     = KIND_LL;
    if (valid && opcode == 6'd0) begin
      unique case (funct)
        FN_SLL:  begin dec.hit = 1'b1; dec.kind = KIND_LL; end
        FN_SRL:  begin dec.hit = 1'b1; dec.kind = KIND_RL; end
        FN_SRA:  begin dec.hit = 1'b1; dec.kind = KIND_RA; end
        FN_SLLV: begin dec.hit = 1'b1; dec.kind = KIND_LL; dec.from_reg = 1'b1; end
        FN_SRLV: begin dec.hit = 1'b1; dec.kind = KIND_RL; dec.from_reg = 1'b1; end
        FN_SRAV: begin dec.hit = 1'b1; dec.kind = KIND_RA; dec.from_reg = 1'b1; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/shift_amount_sel.sv
module shift_amount_sel #(
  parameter int CNT_W = 5
) (
  input  logic             from_reg,
  input  logic [4:0]       field_cnt,
  input  logic [CNT_W-1:0] reg_cnt,
  output logic [CNT_W-1:0] amount
);
  always_comb begin
    amount = from_reg ? reg_cnt : CNT_W'(field_cnt);
  end
endmodule

// File: rtl/shift_core.sv
module shift_core
  import shift_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  shift_kind_e       kind,
  input  logic [CNT_W-1:0]  amount,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result
);
  logic              go_left;
  logic              fill;
  logic [DATA_W-1:0] flipped_in;
  logic [DATA_W-1:0] flipped_out;
  logic [DATA_W-1:0] stage [0:CNT_W];

  assign go_left = (kind == KIND_LL);
  assign fill    = (kind == KIND_RA) & operand[DATA_W-1];

  // Left shifts reuse the right-shift ladder on a bit-reversed word.
  for (genvar b = 0; b < DATA_W; b++) begin : g_rev
    assign flipped_in[b]  = operand[DATA_W-1-b];
    assign flipped_out[b] = stage[CNT_W][DATA_W-1-b];
  end

  assign stage[0] = go_left ? flipped_in : operand;

  for (genvar s = 0; s < CNT_W; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stage[s+1] = amount[s] ? {{SH{fill}}, stage[s][DATA_W-1:SH]} : stage[s];
  end

  assign result = go_left ? flipped_out : stage[CNT_W];

  logic [DATA_W-1:0] low_mask;
  assign low_mask = (DATA_W'(1) << amount) - DATA_W'(1);

  always_comb begin
    assert_zero_count_pass_R10: assert (amount != '0 || result == operand);
    assert_left_low_zero_R4: assert (!go_left || (result & low_mask) == '0);
    assert_rl_top_clear_R5: assert (kind != KIND_RL || amount == '0 || !result[DATA_W-1]);
    assert_ra_sign_kept_R6: assert (kind != KIND_RA || result[DATA_W-1] == operand[DATA_W-1]);
  end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               valid_in,
  input  logic [INSTR_W-1:0] instr_in,
  input  logic [DATA_W-1:0]  rs_val,
  input  logic [DATA_W-1:0]  rt_val,
  output logic [DATA_W-1:0]  result_out,
  output logic               is_shift_out
);
  shift_dec_t        dec;
  logic [CNT_W-1:0]  amount;
  logic [DATA_W-1:0] shifted;
  logic              unused_fields;

  assign unused_fields = ^{instr_in[25:11], rs_val[DATA_W-1:CNT_W]};

  shift_decode u_decode (
    .valid  (valid_in),
    .opcode (instr_in[31:26]),
    .funct  (instr_in[5:0]),
    .dec    (dec)
  );

  shift_amount_sel #(.CNT_W(CNT_W)) u_amount (
    .from_reg  (dec.from_reg),
    .field_cnt (instr_in[10:6]),
    .reg_cnt   (rs_val[CNT_W-1:0]),
    .amount    (amount)
  );

  shift_core #(.DATA_W(DATA_W)) u_core (
    .kind    (dec.kind),
    .amount  (amount),
    .operand (rt_val),
    .result  (shifted)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_out   <= '0;
      is_shift_out <= 1'b0;
    end else begin
      result_out   <= dec.hit ? shifted : '0;
      is_shift_out <= dec.hit;
    end
  end

  assert_flag_needs_valid_R2: assert property (@(posedge clk) disable iff (rst)
    is_shift_out |-> ($past(valid_in) && $past(instr_in[31:26]) == 6'd0));
  assert_idle_result_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !is_shift_out |-> result_out == '0);
  assert_reset_clears_R1: assert property (@(posedge clk)
    $past(rst) |-> (!is_shift_out && result_out == '0));
endmodule

// File: tb/shift_unit_tb.sv
module shift_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_in = 1'b0;
  logic [31:0] instr_in = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [31:0] result_out;
  logic        is_shift_out;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  shift_unit u_dut (
    .clk(clk), .rst(rst), .valid_in(valid_in), .instr_in(instr_in),
    .rs_val(rs_val), .rt_val(rt_val), .result_out(result_out),
    .is_shift_out(is_shift_out)
  );

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] sh,
                                     input logic [5:0] fn);
    return {op, 15'h1234, sh, fn};
  endfunction

  function automatic logic [32:0] model(input logic v, input logic [31:0] ins,
                                        input logic [31:0] rs, input logic [31:0] rt);
    logic [4:0] n;
    n = ins[10:6];
    if (!v || ins[31:26] != 0) return '0;
    case (ins[5:0])
      6'h00: return {1'b1, rt << n};
      6'h02: return {1'b1, rt >> n};
      6'h03: return {1'b1, 32'($signed(rt) >>> n)};
      6'h04: return {1'b1, rt << rs[4:0]};
      6'h06: return {1'b1, rt >> rs[4:0]};
      6'h07: return {1'b1, 32'($signed(rt) >>> rs[4:0])};
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [32:0] exp);
    checks++;
    if ({is_shift_out, result_out} !== exp) begin
      errors++;
      $display("FAIL %s: got flag=%0b res=%h expected flag=%0b res=%h",
               tag, is_shift_out, result_out, exp[32], exp[31:0]);
    end
  endtask

  task automatic run(input string tag, input logic v, input logic [31:0] ins,
                     input logic [31:0] rs, input logic [31:0] rt);
    @(negedge clk);
    valid_in = v; instr_in = ins; rs_val = rs; rt_val = rt;
    @(posedge clk); #1;
    check(tag, model(v, ins, rs, rt));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] fns [8] = '{6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07, 6'h20, 6'h01};
    void'($urandom(32'd2024));
    valid_in = 1'b1; instr_in = mk(0, 5'd3, 6'h00); rt_val = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1 check("R1", '0);
    @(negedge clk); rst = 1'b0;
    valid_in = 1'b0;

    // R4 left logical, fixed
    run("R4", 1, mk(0, 5'd4, 6'h00), 32'h0, 32'h8000_00F1);
    check("R4", {1'b1, 32'h0000_0F10});
    // R5 logical right, fixed
    run("R5", 1, mk(0, 5'd2, 6'h02), 32'h0, 32'h0000_0014);
    check("R5", {1'b1, 32'h0000_0005});
    run("R5", 1, mk(0, 5'd30, 6'h02), 32'h0, 32'hF000_0000);
    check("R5", {1'b1, 32'h0000_0003});
    // R6 arithmetic right
    run("R6", 1, mk(0, 5'd28, 6'h03), 32'h0, 32'h8000_0000);
    check("R6", {1'b1, 32'hFFFF_FFF8});
    run("R6", 1, mk(0, 5'd31, 6'h03), 32'h0, 32'h7FFF_FFFF);
    check("R6", {1'b1, 32'h0});
    // R7 variable forms, upper rs bits ignored
    run("R7", 1, mk(0, 5'd0, 6'h04), 32'hFFFF_FFE1, 32'h0000_0003);
    check("R7", {1'b1, 32'h0000_0006});
    run("R7", 1, mk(0, 5'd9, 6'h06), 32'hABCD_EF28, 32'hFF00_0000);
    check("R7", {1'b1, 32'h00FF_0000});
    run("R7", 1, mk(0, 5'd0, 6'h07), 32'h1234_5664, 32'h8000_0000);
    check("R7", {1'b1, 32'hF800_0000});
    // R8 rs ignored for fixed forms
    run("R8", 1, mk(0, 5'd1, 6'h00), 32'hFFFF_FFFF, 32'h0000_0001);
    check("R8", {1'b1, 32'h0000_0002});
    // R10 zero count
    run("R10", 1, mk(0, 5'd0, 6'h03), 32'h0, 32'hDEAD_BEEF);
    check("R10", {1'b1, 32'hDEAD_BEEF});
    run("R10", 1, mk(0, 5'd7, 6'h06), 32'hFFFF_FFE0, 32'hCAFE_0001);
    check("R10", {1'b1, 32'hCAFE_0001});
    // R2/R3 non-shift decode
    run("R2", 1, mk(6'h08, 5'd3, 6'h00), 32'h0, 32'h1);
    check("R3", '0);
    run("R2", 1, mk(0, 5'd3, 6'h05), 32'h0, 32'h1);
    run("R3", 1, mk(0, 5'd3, 6'h21), 32'h1, 32'h1);
    run("R2", 0, mk(0, 5'd3, 6'h00), 32'h0, 32'h1);
    check("R2", '0);
    // R9 one-cycle latency: output held from previous sample until next edge
    run("R9", 1, mk(0, 5'd8, 6'h00), 32'h0, 32'h0000_00AB);
    @(negedge clk);
    valid_in = 1'b0;
    #1 check("R9", {1'b1, 32'h0000_AB00});
    @(posedge clk); #1 check("R9", '0);

    for (int i = 0; i < 400; i++) begin
      logic [5:0] op;
      logic [31:0] ins;
      op = ($urandom % 8 == 0) ? 6'($urandom) : 6'd0;
      ins = {op, 15'($urandom), 5'($urandom), fns[$urandom % 8]};
      run("R2", ($urandom % 10) != 0, ins, $urandom, $urandom);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule